// File: doc/BRIEF.md
# Hashed Page Table Group Searcher

This block looks up a translation entry in a hashed page table held in memory. A request carries a hash value, the page-size shift set for the segment, a compare tag, the table base and the table mask. The searcher walks the entries of a group one at a time over a simple read port. The port returns one 64-bit word per request, with `rd_valid` marking the returned word. Each entry is two words.

The primary group is scanned first. It sits at `table_base | ((hash & table_mask) << 7)`. If no entry there is accepted, the secondary group is scanned. That group is addressed the same way, but with the bitwise complement of the hash. An entry is accepted when four tests pass:

- it is valid;
- its secondary flag matches the current pass;
- its tag matches the compare tag;
- its page-size encoding in the second word agrees with the segment's page shift.

Entries that fail the page-size test are skipped, and the scan goes on. On completion, `done` pulses for one cycle together with the result. A hit presents the two entry words, the entry's offset from the table base and the decoded page shift. A miss presents an all-ones offset.

The control is one state machine with these states:

- `S_IDLE` waits for `start`.
- `S_REQ_W0` issues the read of the first word.
- `S_WAIT_W0` waits for that word and tests the entry.
- `S_REQ_W1` issues the read of the second word.
- `S_WAIT_W1` waits for that word and decodes the page size.
- `S_STEP` moves to the next entry or the next pass.

The transitions are:

- `S_IDLE`→`S_REQ_W0` on an accepted start.
- `S_REQ_W0`→`S_WAIT_W0`.
- `S_WAIT_W0`→`S_REQ_W1` when the entry is a candidate, or →`S_STEP` when it is not.
- `S_REQ_W1`→`S_WAIT_W1`.
- `S_WAIT_W1`→`S_IDLE` on an accepted size (hit), or →`S_STEP` on a rejected size.
- `S_STEP`→`S_REQ_W0` for the next entry or the secondary pass, or →`S_IDLE` after the last secondary entry (miss).

Top module: `hpt_group_search`

## Requirements
- R1: Group search order and addressing. The primary group uses the hash as given. The secondary group is searched only after the primary group misses, and it uses `~hash`. The group offset is `(h & table_mask) << 7`. Entry `i` lies at offset `group + 16*i`. Its first word is read at `table_base | offset` and its second word at that address plus 8.
- R2: An entry is a candidate only if bit 0 of the first word (valid) is 1. Bit 1 (secondary flag) must also equal the pass: 0 on the primary pass, 1 on the secondary pass.
- R3: A candidate must also have bits 63:7 of the first word equal to `cmp_tag`.
- R4: With a segment shift of 12, every candidate is accepted, with page shift 12.
- R5: With a segment shift of 16, a candidate is accepted only when bits 15:12 of the second word equal 4'b0001. The page shift is then 16.
- R6: With a segment shift of 24, a candidate is accepted only when bits 19:12 of the second word are all zero. The page shift is then 24.
- R7: With any other segment shift, every entry is rejected and the search ends in a miss.
- R8: A rejected entry is skipped and the scan continues. Entries are visited in ascending index order, and the first accepted entry wins.
- R9: When both groups yield no accepted entry, `done` pulses with `hit`=0 and `pte_offset` all ones.
- R10: On a hit, `done` pulses for one cycle with `hit`=1. The two entry words, the entry offset and the page shift are presented in the same cycle and held until the next result.
- R11: A synchronous active-high reset, including one during a search, returns the block to idle with `busy` and `done` low.
- R12: A `start` seen while `busy` is high is ignored. The running search completes with its own result, and only one `done` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a search (taken when not busy) |
| hash | input | HASH_W | Hash value for the primary group |
| seg_shift | input | 6 | Page shift configured for the segment |
| cmp_tag | input | 57 | Tag compared with first-word bits 63:7 |
| table_base | input | ADDR_W | Byte base address of the table |
| table_mask | input | HASH_W | Mask applied to the hash |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Result is a hit |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Memory read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 64 | Read data word |
| pte_w0 | output | 64 | First word of the accepted entry |
| pte_w1 | output | 64 | Second word of the accepted entry |
| pte_offset | output | ADDR_W | Entry byte offset from base, all ones on a miss |
| page_shift | output | 6 | Decoded page shift of the hit |

## Verification
Completion of one search and acceptance of the next can fall in the same cycle. `done` is raised while the machine is already back in `S_IDLE`, so a `start` held during the `done` cycle is taken at once. The bench provokes this by raising `start` in the very cycle it observes `done`. It then checks that the first result was intact in that cycle and that the second search returns its own correct hit. A contrasting case pulses `start` while `busy` is still high, and the bench confirms that the request is dropped and only one completion follows.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_REQ_W0,
        S_WAIT_W0,
        S_REQ_W1,
        S_WAIT_W1,
        S_STEP
    } hpt_state_e;

    // Field positions in the first entry word
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_SEC_BIT   = 1;
    localparam int PTE_TAG_LSB   = 7;
    localparam int PTE_TAG_W     = 64 - PTE_TAG_LSB;

    // Page-size field in the second entry word
    localparam int PTE_SZ_LSB    = 12;
    localparam int PTE_SZ_W      = 8;

    localparam int SHIFT_W       = 6;
    localparam int ENTRY_SHIFT   = 4;   // 16 bytes per entry

endpackage

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int HASH_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic [ADDR_W-1:0]            table_base,
    input  logic [HASH_W-1:0]            table_mask,
    input  logic [HASH_W-1:0]            hash,
    input  logic                         pass_sec,
    input  logic [$clog2(ENTRIES)-1:0]   idx,
    input  logic                         word_hi,
    output logic [ADDR_W-1:0]            entry_off,
    output logic [ADDR_W-1:0]            rd_addr
);

    localparam int IDX_W       = $clog2(ENTRIES);
    localparam int GROUP_SHIFT = IDX_W + ENTRY_SHIFT;

    logic [HASH_W-1:0] hash_sel;
    logic [ADDR_W-1:0] group_off;

    always_comb begin
        hash_sel  = pass_sec ? ~hash : hash;
        group_off = ADDR_W'(hash_sel & table_mask) << GROUP_SHIFT;
        entry_off = group_off + (ADDR_W'(idx) << ENTRY_SHIFT);
        rd_addr   = table_base | (entry_off + (word_hi ? ADDR_W'(8) : ADDR_W'(0)));
    end

endmodule

// File: rtl/hpt_entry_match.sv
module hpt_entry_match
    import hpt_pkg::*;
(
    input  logic                 valid_bit,
    input  logic                 sec_bit,
    input  logic [PTE_TAG_W-1:0] entry_tag,
    input  logic                 pass_sec,
    input  logic [PTE_TAG_W-1:0] cmp_tag,
    output logic                 cand
);

    always_comb begin
        cand = valid_bit && (sec_bit == pass_sec) && (entry_tag == cmp_tag);
    end

endmodule

// File: rtl/hpt_size_decode.sv
module hpt_size_decode
    import hpt_pkg::*;
(
    input  logic [PTE_SZ_W-1:0] size_field,
    input  logic [SHIFT_W-1:0]  seg_shift,
    output logic [SHIFT_W-1:0]  eff_shift
);

    always_comb begin
        case (seg_shift)
            SHIFT_W'(12): eff_shift = SHIFT_W'(12);
            SHIFT_W'(16): eff_shift = (size_field[3:0] == 4'b0001) ? SHIFT_W'(16) : '0;
            SHIFT_W'(24): eff_shift = (size_field == '0) ? SHIFT_W'(24) : '0;
            default:      eff_shift = '0;
        endcase
    end

endmodule

// File: rtl/hpt_group_search.sv
module hpt_group_search
    import hpt_pkg::*;
#(
    parameter int ADDR_W  = 48,
    parameter int HASH_W  = 32,
    parameter int ENTRIES = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [HASH_W-1:0]    hash,
    input  logic [SHIFT_W-1:0]   seg_shift,
    input  logic [PTE_TAG_W-1:0] cmp_tag,
    input  logic [ADDR_W-1:0]    table_base,
    input  logic [HASH_W-1:0]    table_mask,
    output logic                 busy,
    output logic                 done,
    output logic                 hit,
    output logic                 rd_req,
    output logic [ADDR_W-1:0]    rd_addr,
    input  logic                 rd_valid,
    input  logic [63:0]          rd_data,
    output logic [63:0]          pte_w0,
    output logic [63:0]          pte_w1,
    output logic [ADDR_W-1:0]    pte_offset,
    output logic [SHIFT_W-1:0]   page_shift
);

    localparam int IDX_W = $clog2(ENTRIES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    hpt_state_e state, state_nx;

    logic [IDX_W-1:0]     idx_q;
    logic                 pass_q;
    logic [HASH_W-1:0]    hash_q;
    logic [HASH_W-1:0]    mask_q;
    logic [ADDR_W-1:0]    base_q;
    logic [SHIFT_W-1:0]   shift_q;
    logic [PTE_TAG_W-1:0] tag_q;
    logic [63:0]          w0_q;

    logic                 cand;
    logic [SHIFT_W-1:0]   dec_shift;
    logic [ADDR_W-1:0]    entry_off;
    logic                 last_idx;
    logic                 finish_hit;
    logic                 finish_miss;

    hpt_addr_gen #(
        .ADDR_W  (ADDR_W),
        .HASH_W  (HASH_W),
        .ENTRIES (ENTRIES)
    ) u_addr (
        .table_base (base_q),
        .table_mask (mask_q),
        .hash       (hash_q),
        .pass_sec   (pass_q),
        .idx        (idx_q),
        .word_hi    (state == S_REQ_W1),
        .entry_off  (entry_off),
        .rd_addr    (rd_addr)
    );

    hpt_entry_match u_match (
        .valid_bit (rd_data[PTE_VALID_BIT]),
        .sec_bit   (rd_data[PTE_SEC_BIT]),
        .entry_tag (rd_data[63:PTE_TAG_LSB]),
        .pass_sec  (pass_q),
        .cmp_tag   (tag_q),
        .cand      (cand)
    );

    hpt_size_decode u_size (
        .size_field (rd_data[PTE_SZ_LSB +: PTE_SZ_W]),
        .seg_shift  (shift_q),
        .eff_shift  (dec_shift)
    );

    assign last_idx    = (idx_q == LAST_IDX);
    assign busy        = (state != S_IDLE);
    assign rd_req      = (state == S_REQ_W0) || (state == S_REQ_W1);
    assign finish_hit  = (state == S_WAIT_W1) && rd_valid && (dec_shift != '0);
    assign finish_miss = (state == S_STEP) && last_idx && pass_q;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (start) state_nx = S_REQ_W0;
            S_REQ_W0:  state_nx = S_WAIT_W0;
            S_WAIT_W0: if (rd_valid) state_nx = cand ? S_REQ_W1 : S_STEP;
            S_REQ_W1:  state_nx = S_WAIT_W1;
            S_WAIT_W1: if (rd_valid) state_nx = (dec_shift != '0) ? S_IDLE : S_STEP;
            S_STEP:    state_nx = (last_idx && pass_q) ? S_IDLE : S_REQ_W0;
            default:   state_nx = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    // Datapath and result registers
    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q      <= '0;
            pass_q     <= 1'b0;
            hash_q     <= '0;
            mask_q     <= '0;
            base_q     <= '0;
            shift_q    <= '0;
            tag_q      <= '0;
            w0_q       <= '0;
            done       <= 1'b0;
            hit        <= 1'b0;
            pte_w0     <= '0;
            pte_w1     <= '0;
            pte_offset <= '0;
            page_shift <= '0;
        end else begin
            done <= finish_hit || finish_miss;

            if (state == S_IDLE && start) begin
                hash_q  <= hash;
                mask_q  <= table_mask;
                base_q  <= table_base;
                shift_q <= seg_shift;
                tag_q   <= cmp_tag;
                idx_q   <= '0;
                pass_q  <= 1'b0;
            end

            if (state == S_WAIT_W0 && rd_valid) w0_q <= rd_data;

            if (state == S_STEP) begin
                if (last_idx) begin
                    idx_q  <= '0;
                    pass_q <= 1'b1;
                end else begin
                    idx_q  <= idx_q + IDX_W'(1);
                end
            end

            if (finish_hit) begin
                hit        <= 1'b1;
                pte_w0     <= w0_q;
                pte_w1     <= rd_data;
                pte_offset <= entry_off;
                page_shift <= dec_shift;
            end else if (finish_miss) begin
                hit        <= 1'b0;
                pte_w0     <= '0;
                pte_w1     <= '0;
                pte_offset <= '1;
                page_shift <= '0;
            end
        end
    end

endmodule

// File: rtl/hpt_group_search_chk.sv
module hpt_group_search_chk #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              hit,
    input logic              rd_req,
    input logic              pte_valid,
    input logic [7:0]        pte_size,
    input logic [ADDR_W-1:0] pte_offset,
    input logic [5:0]        page_shift,
    input logic [HASH_W-1:0] hash_q
);

    // R11
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!done && !busy));

    // R9
    miss_offset_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !hit) |-> (&pte_offset));

    // R10
    hit_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> (page_shift == 6'd12 || page_shift == 6'd16 || page_shift == 6'd24));

    // R2
    hit_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit) |-> pte_valid);

    // R5
    hit_64k_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit && page_shift == 6'd16) |-> (pte_size[3:0] == 4'b0001));

    // R6
    hit_16m_chk: assert property (@(posedge clk) disable iff (rst)
        (done && hit && page_shift == 6'd24) |-> (pte_size == 8'h00));

    // R12
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(hash_q));

    // R1
    rd_busy_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (busy && !done));

endmodule

bind hpt_group_search hpt_group_search_chk #(
    .ADDR_W (ADDR_W),
    .HASH_W (HASH_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .busy       (busy),
    .done       (done),
    .hit        (hit),
    .rd_req     (rd_req),
    .pte_valid  (pte_w0[0]),
    .pte_size   (pte_w1[19:12]),
    .pte_offset (pte_offset),
    .page_shift (page_shift),
    .hash_q     (hash_q)
);

// File: tb/hpt_group_search_bench.sv
module hpt_group_search_bench;

    localparam int ADDR_W = 48;
    localparam int HASH_W = 32;
    localparam logic [ADDR_W-1:0] BASE = 48'h0000_4000_0000;
    localparam logic [HASH_W-1:0] MASK = 32'h0000_000F;
    localparam logic [56:0] TAG_A = 57'h1234;
    localparam logic [56:0] TAG_B = 57'h0ABC;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              start = 1'b0;
    logic [HASH_W-1:0] hash = '0;
    logic [5:0]        seg_shift = '0;
    logic [56:0]       cmp_tag = '0;
    logic              busy, done, hit, rd_req;
    logic [ADDR_W-1:0] rd_addr, pte_offset;
    logic              rd_valid = 1'b0;
    logic [63:0]       rd_data = '0;
    logic [63:0]       pte_w0, pte_w1;
    logic [5:0]        page_shift;

    logic [63:0] mem [256];
    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    hpt_group_search u_hpt_group_search (
        .clk, .rst, .start, .hash, .seg_shift, .cmp_tag,
        .table_base (BASE), .table_mask (MASK),
        .busy, .done, .hit, .rd_req, .rd_addr, .rd_valid, .rd_data,
        .pte_w0, .pte_w1, .pte_offset, .page_shift
    );

    // One-cycle-latency memory model
    always @(posedge clk) begin
        rd_valid <= rd_req && !rst;
        rd_data  <= mem[rd_addr[10:3]];
    end

    always @(negedge clk) if (!rst && done) done_cnt++;

    typedef struct packed {
        logic [31:0] h;
        logic [5:0]  s;
        logic        use_b;
        logic        exp_hit;
        logic        exp_pass;
        logic [2:0]  exp_idx;
        logic [5:0]  exp_shift;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{32'd1,    6'd12, 1'b0, 1'b1, 1'b0, 3'd3, 6'd12}, // R4 R3 R8: idx0 wrong tag, idx1 invalid, idx2 wrong pass
        '{32'd1,    6'd16, 1'b0, 1'b1, 1'b0, 3'd4, 6'd16}, // R5: idx3 size code 2 skipped
        '{32'd1,    6'd24, 1'b0, 1'b1, 1'b0, 3'd5, 6'd24}, // R6: idx3, idx4 nonzero size field skipped
        '{32'd1,    6'd20, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0 }, // R7: unsupported shift -> miss
        '{32'd1,    6'd16, 1'b1, 1'b1, 1'b1, 3'd1, 6'd16}, // R1 R8: primary candidate rejected, secondary hit
        '{32'd14,   6'd12, 1'b0, 1'b1, 1'b1, 3'd2, 6'd12}, // R2: secondary-flag entry only on pass 1
        '{32'd3,    6'd12, 1'b0, 1'b0, 1'b0, 3'd0, 6'd0 }, // R9: empty groups -> miss
        '{32'h31,   6'd24, 1'b0, 1'b1, 1'b0, 3'd5, 6'd24}, // R1: mask applied to hash
        '{32'd14,   6'd16, 1'b0, 1'b1, 1'b1, 3'd2, 6'd16}  // R5 R1: secondary hit at 64K
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R4";
            1: return "R5";
            2: return "R6";
            3: return "R7";
            4: return "R8";
            5: return "R2";
            6: return "R9";
            7: return "R1";
            default: return "R10";
        endcase
    endfunction

    function automatic logic [63:0] mk_w0(logic [56:0] tag, logic sec, logic v);
        return {tag, 5'b0, sec, v};
    endfunction

    function automatic logic [ADDR_W-1:0] exp_off(logic [31:0] h, logic p, int idx);
        logic [31:0] hs;
        hs = p ? ~h : h;
        return (ADDR_W'(hs & MASK) << 7) + ADDR_W'(idx * 16);
    endfunction

    task automatic put(int grp, int idx, logic [63:0] w0, logic [63:0] w1);
        mem[grp*16 + idx*2]     = w0;
        mem[grp*16 + idx*2 + 1] = w1;
    endtask

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic wait_done(string req);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            errors++;
            $display("FAIL %s done timeout actual=0 expected=1", req);
        end
    endtask

    task automatic run_search(logic [31:0] h, logic [5:0] s, logic [56:0] t, string req);
        @(negedge clk);
        hash = h; seg_shift = s; cmp_tag = t; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(req);
    endtask

    task automatic check_result(string req, logic eh, logic p, int idx, logic [5:0] sh);
        logic [ADDR_W-1:0] off;
        check(req, "hit", 64'(hit), 64'(eh));
        if (eh) begin
            off = exp_off(hash, p, idx);
            check(req, "offset", 64'(pte_offset), 64'(off));
            check(req, "shift", 64'(page_shift), 64'(sh));
            check(req, "w0", pte_w0, mem[off[10:3]]);
            check(req, "w1", pte_w1, mem[off[10:3] + 8'd1]);
        end else begin
            check(req, "offset", 64'(pte_offset), 64'(48'hFFFF_FFFF_FFFF));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int base_cnt;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // group 1
        put(1, 0, mk_w0(TAG_B, 1'b0, 1'b1), 64'h0000_0000_0000_3000);
        put(1, 1, mk_w0(TAG_A, 1'b0, 1'b0), 64'h0);
        put(1, 2, mk_w0(TAG_A, 1'b1, 1'b1), 64'h0000_0000_0000_1000);
        put(1, 3, mk_w0(TAG_A, 1'b0, 1'b1), 64'hABCD_0000_0000_2000);
        put(1, 4, mk_w0(TAG_A, 1'b0, 1'b1), 64'h1111_0000_0001_1000);
        put(1, 5, mk_w0(TAG_A, 1'b0, 1'b1), 64'h2222_0000_0F00_0FFF);
        // group 14
        put(14, 0, mk_w0(TAG_A, 1'b1, 1'b1), 64'h0);
        put(14, 1, mk_w0(TAG_B, 1'b1, 1'b1), 64'h5555_0000_0000_1000);

        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11", "busy", 64'(busy), 64'd0);
        check("R11", "done", 64'(done), 64'd0);
        check("R11", "rd_req", 64'(rd_req), 64'd0);
        rst = 1'b0;

        // R1: first read address of the primary group
        @(negedge clk);
        hash = 32'd1; seg_shift = 6'd12; cmp_tag = TAG_A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R1", "rd_req", 64'(rd_req), 64'd1);
        check("R1", "rd_addr", 64'(rd_addr), 64'(BASE | 48'h80));
        wait_done("R1");
        check_result("R1", 1'b1, 1'b0, 3, 6'd12);

        // Vector table
        for (int v = 0; v < 9; v++) begin
            run_search(VECS[v].h, VECS[v].s, VECS[v].use_b ? TAG_B : TAG_A, vec_req(v));
            check_result(vec_req(v), VECS[v].exp_hit, VECS[v].exp_pass,
                         int'(VECS[v].exp_idx), VECS[v].exp_shift);
            check("R10", "done pulse width", 64'(done), 64'd1);
            @(negedge clk);
            check("R10", "done low after pulse", 64'(done), 64'd0);
        end

        // R12: start while busy is dropped
        base_cnt = done_cnt;
        @(negedge clk);
        hash = 32'd1; seg_shift = 6'd12; cmp_tag = TAG_A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (2) @(negedge clk);
        hash = 32'd3; seg_shift = 6'd20; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        hash = 32'd1;
        wait_done("R12");
        check_result("R12", 1'b1, 1'b0, 3, 6'd12);
        repeat (100) @(negedge clk);
        check("R12", "done count", 64'(done_cnt - base_cnt), 64'd1);
        check("R12", "busy", 64'(busy), 64'd0);

        // Completion and new start in the same cycle
        run_search(32'd1, 6'd24, TAG_A, "R10");
        check_result("R10", 1'b1, 1'b0, 5, 6'd24);
        hash = 32'd14; seg_shift = 6'd12; cmp_tag = TAG_A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10", "busy after back-to-back start", 64'(busy), 64'd1);
        wait_done("R10");
        check_result("R2", 1'b1, 1'b1, 2, 6'd12);

        // R11: reset during a search
        @(negedge clk);
        hash = 32'd3; seg_shift = 6'd12; cmp_tag = TAG_A; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        base_cnt = done_cnt;
        rst = 1'b1;
        @(negedge clk);
        check("R11", "busy after mid reset", 64'(busy), 64'd0);
        check("R11", "done after mid reset", 64'(done), 64'd0);
        rst = 1'b0;
        repeat (100) @(negedge clk);
        check("R11", "no done after reset", 64'(done_cnt - base_cnt), 64'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule